// File: doc/BRIEF.md
# DRAM Refresh and Initialization Controller

This block keeps an asynchronous DRAM array alive. After reset it sits quiet for the power-up pause. It then runs a fixed burst of warm-up refresh cycles and raises a ready flag. From then on it issues one refresh per slot of the retention window. The default is 2048 rows per 32 ms, which gives one slot every 3906 clocks at a 4 ns clock. The clock period and every timing are parameters given in nanoseconds. They are turned into whole cycles by rounding up.

The strobe bus is shared with the access sequencer. When refresh work is owed, the controller raises a request and waits for the grant. It drives the row strobe, the column strobes and write enable only while the grant is held. It keeps the request up until the grant arrives. If slots are missed while the grant is withheld, they are counted up to a fixed ceiling. The counted slots are then run back to back under a single grant. A mode input picks the refresh type for each cycle. In column-before-row refresh the device's internal counter supplies the row. In row-only refresh the controller's own counter drives the row address pins and the bank bit. The control pins here are plain levels. There is no data stream and no back-pressure beyond the request/grant pair.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset, the request stays low and the ready flag stays low for at least the pause length (ceil(PAUSE_NS/CLK_NS) cycles). No row strobe falls before that many cycles.
- R2: After the pause, exactly INIT_CYCLES (default 8) refresh cycles run. Ready rises when the precharge of the last of them ends, and it never falls afterwards.
- R3: When the grant follows the request at once, successive refresh row-strobe falls after ready are exactly floor(RETENTION_NS/ROWS_PER_WINDOW/CLK_NS) cycles apart.
- R4: The request stays high until the grant arrives. The row strobe is low only while the request and the grant are both high. No strobe moves while the grant is withheld.
- R5: In column-before-row mode, all column strobes are low for at least ceil(CSR_NS/CLK_NS) cycles before the row strobe falls. They stay low for at least ceil(CHR_NS/CLK_NS) cycles after it falls. They are all high again before the row strobe rises.
- R6: Write enable (active low) is high at all times.
- R7: The row strobe is low for at least ceil(RAS_NS/CLK_NS) cycles. It is high for at least ceil(RP_NS/CLK_NS) cycles between refreshes. Falls are at least ceil(TRC_NS/CLK_NS) cycles apart.
- R8: In row-only mode the column strobes stay all high. The row pins and the bank bit carry a counter, with the bank bit as its most significant bit. The counter starts at 0 after reset and advances by one after each row-only cycle.
- R9: Missed slots are counted up to MAX_PEND (default 4), and further slots are dropped. Once the grant is given, exactly that many cycles run back to back without the request dropping.
- R10: The mode input is sampled when a cycle starts. Changing it during a cycle leaves that cycle's strobes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| row_only_mode | input | 1 | 1 = row-only refresh, 0 = column-before-row refresh |
| bus_grant | input | 1 | Strobe bus handed to this block |
| bus_req | output | 1 | Strobe bus wanted |
| init_done | output | 1 | Warm-up complete; accesses may start |
| ref_ras_n | output | 1 | Row strobe, active low |
| ref_cas_n | output | CAS_W | Column strobes, active low |
| ref_we_n | output | 1 | Write enable, active low |
| ref_row | output | ROW_W | Row address for row-only refresh |
| ref_bank | output | 1 | Extra bank address bit for row-only refresh |

## Verification
The hardest case to reach is the accumulation of missed slots. The grant must be held back across several refresh intervals and then released in the middle of an interval, so that no fresh slot lands during the catch-up burst. The bench shortens the pause and the retention window through parameters. It withholds the grant for six and a half intervals, just after a cycle has ended, and then counts the row-strobe falls until the request drops. A mode flip made one cycle after a row-strobe fall reaches the other hard case. That is the one where a change to the mode input in the middle of a cycle must not disturb the strobes already in flight.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_SETUP,
    SQ_ACT,
    SQ_PRE
  } seq_state_t;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfc_timer.sv
module rfc_timer #(
  parameter int PAUSE_CYC = 50000,
  parameter int INT_CYC   = 3906
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pause_done,
  output logic tick
);
  localparam int MAXC = (PAUSE_CYC > INT_CYC) ? PAUSE_CYC : INT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic          pause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pause_q <= 1'b0;
    end else if (!pause_q) begin
      if (cnt == CW'(PAUSE_CYC - 1)) begin
        pause_q <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (run) begin
      if (cnt == CW'(INT_CYC - 1)) cnt <= '0;
      else                         cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
    end
  end

  assign pause_done = pause_q;
  assign tick       = pause_q && run && (cnt == CW'(INT_CYC - 1));
endmodule

// File: rtl/rfc_ledger.sv
module rfc_ledger #(
  parameter int INIT_CYCLES = 8,
  parameter int MAX_PEND    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_done,
  input  logic tick,
  input  logic done,
  input  logic cyc_end,
  output logic work,
  output logic ready
);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam int PW = $clog2(MAX_PEND + 1);

  logic [IW-1:0] init_left;
  logic [PW-1:0] pend;
  logic          ready_q;
  logic          init_phase, inc, dec;

  assign init_phase = (init_left != '0);
  assign dec        = done && !init_phase && (pend != '0);
  assign inc        = tick && ((pend != PW'(MAX_PEND)) || dec);
  assign work       = pause_done && (init_phase || (pend != '0));
  assign ready      = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_left <= IW'(INIT_CYCLES);
      pend      <= '0;
      ready_q   <= 1'b0;
    end else begin
      if (pause_done && done && init_phase) init_left <= init_left - 1'b1;
      case ({inc, dec})
        2'b10:   pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
      if (cyc_end && !init_phase && pause_done) ready_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rfc_strobe_seq.sv
module rfc_strobe_seq
  import rfc_pkg::*;
#(
  parameter int CSR_CYC = 4,
  parameter int ASR_CYC = 2,
  parameter int CHR_CYC = 3,
  parameter int RAS_CYC = 15,
  parameter int RPE_CYC = 13,
  parameter int CAS_W   = 8,
  parameter int ROW_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             work,
  input  logic             row_only,
  input  logic             grant,
  output logic             req,
  output logic             done,
  output logic             cyc_end,
  output logic             ras_n,
  output logic [CAS_W-1:0] cas_n,
  output logic [ROW_W-1:0] row,
  output logic             bank
);
  localparam int MAXT = imax(imax(CSR_CYC, ASR_CYC), imax(RAS_CYC, RPE_CYC));
  localparam int TW   = $clog2(MAXT + 1);

  seq_state_t    state;
  logic [TW-1:0] cnt;
  logic [TW-1:0] setup_last;
  logic          cbr_q;
  logic [ROW_W:0] row_cnt;
  logic          cas_low;

  assign setup_last = cbr_q ? TW'(CSR_CYC - 1) : TW'(ASR_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      req     <= 1'b0;
      cbr_q   <= 1'b1;
      row_cnt <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (work) begin
          req   <= 1'b1;
          state <= SQ_WAIT;
        end
        SQ_WAIT: if (grant) begin
          state <= SQ_SETUP;
          cnt   <= '0;
          cbr_q <= ~row_only;
        end
        SQ_SETUP: if (cnt == setup_last) begin
          state <= SQ_ACT;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        SQ_ACT: if (cnt == TW'(RAS_CYC - 1)) begin
          state <= SQ_PRE;
          cnt   <= '0;
          if (!cbr_q) row_cnt <= row_cnt + 1'b1;
        end else cnt <= cnt + 1'b1;
        SQ_PRE: if (cnt == TW'(RPE_CYC - 1)) begin
          cnt <= '0;
          if (work) begin
            state <= SQ_SETUP;
            cbr_q <= ~row_only;
          end else begin
            state <= SQ_IDLE;
            req   <= 1'b0;
          end
        end else cnt <= cnt + 1'b1;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign done    = (state == SQ_ACT) && (cnt == TW'(RAS_CYC - 1));
  assign cyc_end = (state == SQ_PRE) && (cnt == TW'(RPE_CYC - 1));
  assign cas_low = cbr_q && ((state == SQ_SETUP) ||
                             ((state == SQ_ACT) && (cnt < TW'(CHR_CYC))));
  assign ras_n   = (state != SQ_ACT);
  assign cas_n   = {CAS_W{~cas_low}};
  assign row     = row_cnt[ROW_W-1:0];
  assign bank    = row_cnt[ROW_W];
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import rfc_pkg::*;
#(
  parameter int CLK_NS          = 4,
  parameter int PAUSE_NS        = 200000,
  parameter int INIT_CYCLES     = 8,
  parameter int RETENTION_NS    = 32000000,
  parameter int ROWS_PER_WINDOW = 2048,
  parameter int MAX_PEND        = 4,
  parameter int CSR_NS          = 15,
  parameter int CHR_NS          = 10,
  parameter int ASR_NS          = 5,
  parameter int RAS_NS          = 60,
  parameter int RP_NS           = 40,
  parameter int RPC_NS          = 10,
  parameter int TRC_NS          = 110,
  parameter int CAS_W           = 8,
  parameter int ROW_W           = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_only_mode,
  input  logic             bus_grant,
  output logic             bus_req,
  output logic             init_done,
  output logic             ref_ras_n,
  output logic [CAS_W-1:0] ref_cas_n,
  output logic             ref_we_n,
  output logic [ROW_W-1:0] ref_row,
  output logic             ref_bank
);
  localparam int PAUSE_CYC = ns2cyc(PAUSE_NS, CLK_NS);
  localparam int INT_CYC   = (RETENTION_NS / ROWS_PER_WINDOW) / CLK_NS;
  localparam int CSR_CYC   = ns2cyc(CSR_NS, CLK_NS);
  localparam int CHR_CYC   = ns2cyc(CHR_NS, CLK_NS);
  localparam int ASR_CYC   = imax(1, ns2cyc(ASR_NS, CLK_NS));
  localparam int RAS_CYC   = imax(CHR_CYC + 1, ns2cyc(RAS_NS, CLK_NS));
  localparam int RPE_CYC   = imax(imax(ns2cyc(RP_NS, CLK_NS), ns2cyc(RPC_NS, CLK_NS)),
                                  ns2cyc(TRC_NS, CLK_NS) - RAS_CYC);

  logic pause_done, tick, work, done, cyc_end;

  rfc_timer #(.PAUSE_CYC(PAUSE_CYC), .INT_CYC(INT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(init_done),
    .pause_done(pause_done), .tick(tick)
  );

  rfc_ledger #(.INIT_CYCLES(INIT_CYCLES), .MAX_PEND(MAX_PEND)) u_ledger (
    .clk(clk), .rst_n(rst_n), .pause_done(pause_done), .tick(tick),
    .done(done), .cyc_end(cyc_end), .work(work), .ready(init_done)
  );

  rfc_strobe_seq #(
    .CSR_CYC(CSR_CYC), .ASR_CYC(ASR_CYC), .CHR_CYC(CHR_CYC),
    .RAS_CYC(RAS_CYC), .RPE_CYC(RPE_CYC), .CAS_W(CAS_W), .ROW_W(ROW_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .work(work), .row_only(row_only_mode),
    .grant(bus_grant), .req(bus_req), .done(done), .cyc_end(cyc_end),
    .ras_n(ref_ras_n), .cas_n(ref_cas_n), .row(ref_row), .bank(ref_bank)
  );

  assign ref_we_n = 1'b1;
endmodule

// File: rtl/dram_refresh_ctrl_checker.sv
module dram_refresh_ctrl_checker #(
  parameter int CAS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_grant,
  input logic             init_done,
  input logic             ref_ras_n,
  input logic [CAS_W-1:0] ref_cas_n
);
  assert_strobe_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ras_n |-> (bus_grant && bus_req));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_grant) |=> bus_req);

  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_cas_at_ras_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_ras_n) |-> (($past(ref_cas_n) == '0) || (ref_cas_n == '1)));

  assert_cas_high_at_ras_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_ras_n) |-> (ref_cas_n == '1));
endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_checker #(.CAS_W(CAS_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_grant(bus_grant),
  .init_done(init_done), .ref_ras_n(ref_ras_n), .ref_cas_n(ref_cas_n)
);

// File: tb/dram_refresh_ctrl_bench.sv
module dram_refresh_ctrl_bench;
  localparam int CLK_NS    = 4;
  localparam int PAUSE_NS  = 20000;
  localparam int RET_NS    = 8192000;
  localparam int CAS_W     = 8;
  localparam int ROW_W     = 11;
  localparam int PAUSE_CYC = 5000;
  localparam int INT_CYC   = 1000;
  localparam int CSR_CYC   = 4;
  localparam int CHR_CYC   = 3;
  localparam int RAS_CYC   = 15;
  localparam int RP_CYC    = 10;
  localparam int TRC_CYC   = 28;
  localparam int MAX_PEND  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_only_mode = 1'b0;
  logic allow = 1'b1;
  logic bus_grant, bus_req, init_done, ref_ras_n, ref_we_n, ref_bank;
  logic [CAS_W-1:0] ref_cas_n;
  logic [ROW_W-1:0] ref_row;

  always #2 clk = ~clk;
  assign bus_grant = bus_req & allow;

  dram_refresh_ctrl #(.CLK_NS(CLK_NS), .PAUSE_NS(PAUSE_NS), .RETENTION_NS(RET_NS),
                      .MAX_PEND(MAX_PEND), .CAS_W(CAS_W), .ROW_W(ROW_W)) u_dram_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .row_only_mode(row_only_mode), .bus_grant(bus_grant),
    .bus_req(bus_req), .init_done(init_done), .ref_ras_n(ref_ras_n),
    .ref_cas_n(ref_cas_n), .ref_we_n(ref_we_n), .ref_row(ref_row), .ref_bank(ref_bank)
  );

  int tests = 0, fails = 0;
  int exp_q[$];
  int mrow = 0;
  int cyc = 0, nfalls = 0, burst_falls = 0, last_fall = 0, last_gap = 0;
  int ras_low_run = 0, ras_high_run = 0, cas_low_run = 0;
  logic prev_ras = 1'b1, prev_cas_low = 1'b0, prev_ready = 1'b0;
  bit finished = 0;

  task automatic check(input bit ok, input string rq, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, expv, cyc);
    end
  endtask

  task automatic push_cbr(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(-1);
  endtask

  task automatic push_row(input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(mrow & 12'hfff);
      mrow++;
    end
  endtask

  task automatic wait_falls(input int target, input int limit);
    int t = 0;
    while (nfalls < target && t < limit) begin
      @(negedge clk);
      t++;
    end
    check(nfalls >= target, "R3 refresh arrival", nfalls, target);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      bit cas_low;
      cyc++;
      cas_low = (ref_cas_n == '0);
      if (prev_ras && !ref_ras_n) begin
        nfalls++;
        burst_falls++;
        if (nfalls == 1) check(cyc >= PAUSE_CYC, "R1 first refresh after pause", cyc, PAUSE_CYC);
        else begin
          last_gap = cyc - last_fall;
          check(last_gap >= TRC_CYC, "R7 fall-to-fall", last_gap, TRC_CYC);
          check(ras_high_run >= RP_CYC, "R7 precharge", ras_high_run, RP_CYC);
        end
        last_fall = cyc;
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected refresh", nfalls, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          if (e < 0) begin
            check(cas_low, "R5 cas low at ras fall", ref_cas_n, 0);
            check(cas_low_run >= CSR_CYC, "R5 cas setup", cas_low_run, CSR_CYC);
          end else begin
            check(&ref_cas_n, "R8 cas high in row-only", ref_cas_n, 255);
            check({ref_bank, ref_row} == 12'(e), "R8 row counter", {ref_bank, ref_row}, e);
          end
        end
      end
      if (!prev_ras && ref_ras_n) begin
        check(ras_low_run >= RAS_CYC, "R7 ras low width", ras_low_run, RAS_CYC);
        check(&ref_cas_n, "R5 cas high at ras rise", ref_cas_n, 255);
      end
      if (!ref_ras_n && prev_cas_low && !cas_low)
        check(ras_low_run >= CHR_CYC, "R5 cas hold", ras_low_run, CHR_CYC);
      if (!ref_we_n) check(1'b0, "R6 we high", ref_we_n, 1);
      if (prev_ready && !init_done) check(1'b0, "R2 ready sticky", init_done, 1);
      if (ref_ras_n) begin ras_high_run++; ras_low_run = 0; end
      else begin ras_low_run++; ras_high_run = 0; end
      cas_low_run = cas_low ? cas_low_run + 1 : 0;
      prev_ras = ref_ras_n;
      prev_cas_low = cas_low;
      prev_ready = init_done;
      if (cyc > 150000 && !finished) begin
        finished = 1;
        check(1'b0, "R2 watchdog expired", cyc, 150000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int t;
    repeat (4) @(negedge clk);
    check(bus_req == 1'b0 && init_done == 1'b0 && ref_ras_n == 1'b1 && ref_cas_n == '1,
          "R1 reset state", {bus_req, init_done}, 0);
    rst_n = 1'b1;
    push_cbr(8);
    // R1: quiet through the pause
    repeat (PAUSE_CYC - 2) @(negedge clk);
    check(!bus_req, "R1 no request during pause", bus_req, 0);
    check(!init_done, "R1 not ready during pause", init_done, 0);
    // R2: warm-up burst then ready
    t = 0;
    while (!init_done && t < 2000) begin @(negedge clk); t++; end
    check(init_done, "R2 ready rises", init_done, 1);
    check(nfalls == 8, "R2 warm-up count", nfalls, 8);
    check(ref_ras_n && !bus_req, "R2 ready after last precharge", {ref_ras_n, bus_req}, 2);
    // R3: steady rate
    push_cbr(3);
    wait_falls(9, 3000);
    wait_falls(10, 3000);
    check(last_gap == INT_CYC, "R3 interval", last_gap, INT_CYC);
    wait_falls(11, 3000);
    check(last_gap == INT_CYC, "R3 interval", last_gap, INT_CYC);
    // R10: flip mode mid-cycle, current cycle stays column-before-row
    row_only_mode = 1'b1;
    @(negedge clk);
    check(ref_cas_n == '0 && !ref_ras_n, "R10 mode sampled at cycle start", ref_cas_n, 0);
    // R8: row-only cycles
    push_row(3);
    wait_falls(14, 4000);
    // R9 / R4: withhold grant across several slots
    t = 0;
    while ((bus_req || !ref_ras_n) && t < 200) begin @(negedge clk); t++; end
    allow = 1'b0;
    repeat (6500) @(negedge clk);
    check(bus_req, "R4 request held without grant", bus_req, 1);
    check(nfalls == 14, "R4 no strobes without grant", nfalls, 14);
    push_row(MAX_PEND);
    burst_falls = 0;
    allow = 1'b1;
    t = 0;
    while (bus_req && t < 1000) begin @(negedge clk); t++; end
    check(burst_falls == MAX_PEND, "R9 catch-up burst", burst_falls, MAX_PEND);
    // back to column-before-row
    row_only_mode = 1'b0;
    push_cbr(2);
    wait_falls(14 + MAX_PEND + 2, 3000);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    check(init_done, "R2 ready still high", init_done, 1);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule